// File: doc/BRIEF.md
# Zero-Address Stack Execution Core

This core runs short programs whose instructions carry no register or operand fields. Every operand is taken from a small on-chip stack of 32-bit words, and a word-addressed data memory is reached only through explicit push-from-memory and pop-to-memory instructions. Arithmetic instructions pop the two topmost words and push one result. Programs and data are written into two internal memories through preload ports while the core is stopped. A `start` pulse then runs the program from address zero, one instruction per clock, until a halt instruction or a stack fault.

The controller has three states. IDLE is entered from reset. RUN executes the instruction addressed by the program counter on every clock. DONE is the stopped state after a halt or a fault. The transitions are as follows. IDLE goes to RUN on `start`. RUN goes to DONE on a halt-class opcode, on an overflow or on an underflow. DONE goes to RUN on `start`. In every other case the state is held. Results are read back through the data preload port once `halted` is high.

Top module: `sm_core`

## Requirements
- R1: After reset the core is in IDLE with `halted`, `err_overflow` and `err_underflow` low, the stack empty and the program counter at zero.
- R2: A `start` pulse seen in IDLE or DONE clears the stack, the program counter and both error flags, and enters RUN. One instruction executes per clock from address 0. `halted` rises exactly N clocks after the start edge when the Nth instruction executed is the halt or the faulting one, and it stays high until the next `start`.
- R3: A push (LOAD or DUP) while 8 entries are held sets `err_overflow` and halts. The stack and the data memory are left unchanged, and no later instruction runs.
- R4: STORE or DUP with an empty stack, or ADD or MUL with fewer than two entries, sets `err_underflow` and halts. Nothing is written, and no later instruction runs.
- R5: An instruction is 16 bits. Bits 15:12 hold the opcode and bits 11:0 hold the address. The codes are 0 halt, 1 LOAD, 2 STORE, 3 ADD, 4 MUL and 5 DUP. Codes 6 to 15 halt like code 0 and raise no error flag.
- R6: LOAD pushes the data word at the address given by the low 6 bits of the address field. The upper address bits are not decoded.
- R7: STORE pops the top entry and writes it to the data word at the low 6 bits of the address field.
- R8: ADD and MUL pop two entries, with the second entry as the left operand and the top entry as the right operand. They push the low 32 bits of the sum or the product, so the depth drops by one.
- R9: DUP pushes a copy of the top entry and keeps the original.
- R10: The address field has no effect on ADD, MUL or DUP.
- R11: Preload writes to either memory are accepted only while the core is not in RUN. While not in RUN, `dmem_rdata` returns the data word at `dmem_addr`.
- R12: Entries are reached in last-in first-out order. A balanced expression leaves the stack at the depth it started from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution from address 0 (IDLE or DONE only) |
| imem_we | input | 1 | Program memory preload write enable |
| imem_addr | input | 6 | Program memory preload address |
| imem_wdata | input | 16 | Program memory preload data |
| dmem_we | input | 1 | Data memory preload write enable |
| dmem_addr | input | 6 | Data memory preload and readback address |
| dmem_wdata | input | 32 | Data memory preload data |
| dmem_rdata | output | 32 | Data memory readback word |
| halted | output | 1 | Core is in DONE |
| err_overflow | output | 1 | Push attempted on a full stack |
| err_underflow | output | 1 | Pop attempted with too few entries |

## Verification
Every instruction takes effect on the clock edge that executes it. For a program whose Nth executed instruction halts or faults, `halted` and the error flags therefore change on the Nth edge after the edge that sampled `start`. The bench drives inputs on falling edges and counts falling edges from the start pulse until `halted` is seen. It compares that count with N, which is computed by hand from the program. Memory results and preserved words are read back only after `halted`, through the combinational readback port, half a cycle away from any active edge.

// File: rtl/sm_pkg.sv
package sm_pkg;
    localparam int INSTR_W = 16;
    localparam int OP_W    = 4;
    localparam int FIELD_W = INSTR_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_HALT  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_ADD   = 4'd3,
        OP_MUL   = 4'd4,
        OP_DUP   = 4'd5
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } state_e;
endpackage

// File: rtl/sm_ram.sv
module sm_ram #(
    parameter int DW = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sm_alu.sv
module sm_alu #(
    parameter int DW = 32
) (
    input  logic          do_mul,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] rhs,
    output logic [DW-1:0] res
);
    always_comb begin
        if (do_mul) res = lhs * rhs;
        else        res = lhs + rhs;
    end
endmodule

// File: rtl/sm_stack.sv
module sm_stack #(
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           push,
    input  logic                           pop,
    input  logic                           combine,
    input  logic [DW-1:0]                  wdata,
    output logic [DW-1:0]                  top,
    output logic [DW-1:0]                  second,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] ent [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cm1, cm2;
    logic          unused_msb;

    assign cm1 = cnt_q - CW'(1);
    assign cm2 = cnt_q - CW'(2);
    assign unused_msb = cm1[CW-1] ^ cm2[CW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((push && cnt_q == CW'(i)) || (combine && cm2 == CW'(i)))
                    ent[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (clear)         cnt_q <= '0;
        else if (push)          cnt_q <= cnt_q + CW'(1);
        else if (pop || combine) cnt_q <= cm1;
    end

    assign top    = ent[cm1[IW-1:0]];
    assign second = ent[cm2[IW-1:0]];
    assign count  = cnt_q;
endmodule

// File: rtl/sm_core.sv
module sm_core
    import sm_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 8,
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_addr,
    input  logic [INSTR_W-1:0] imem_wdata,
    input  logic               dmem_we,
    input  logic [DMEM_AW-1:0] dmem_addr,
    input  logic [DATA_W-1:0]  dmem_wdata,
    output logic [DATA_W-1:0]  dmem_rdata,
    output logic               halted,
    output logic               err_overflow,
    output logic               err_underflow
);
    localparam int CW = $clog2(DEPTH + 1);

    state_e               state_q, state_d;
    logic [IMEM_AW-1:0]   pc_q;
    logic                 ovf_q, udf_q;
    logic                 running;
    logic [INSTR_W-1:0]   instr;
    op_e                  opcode;
    logic [FIELD_W-1:0]   field;
    logic [DMEM_AW-1:0]   maddr;
    logic                 unused_field;

    logic [DATA_W-1:0]    stk_top, stk_second, stk_wdata, alu_res, mem_rd;
    logic [CW-1:0]        stk_count;
    logic                 stk_full, stk_empty, stk_two;

    logic                 do_push, do_pop, do_comb, do_store;
    logic                 ovf_set, udf_set, stop, restart;

    assign running      = (state_q == S_RUN);
    assign opcode       = op_e'(instr[INSTR_W-1:FIELD_W]);
    assign field        = instr[FIELD_W-1:0];
    assign maddr        = field[DMEM_AW-1:0];
    assign unused_field = ^field[FIELD_W-1:DMEM_AW];
    assign stk_full     = (stk_count == CW'(DEPTH));
    assign stk_empty    = (stk_count == '0);
    assign stk_two      = (stk_count >= CW'(2));
    assign restart      = start && !running;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (stop || ovf_set || udf_set) state_d = S_DONE;
            S_DONE:  if (start) state_d = S_RUN;
            default: state_d = S_IDLE;
        endcase
    end

    // Control outputs of the executing instruction
    always_comb begin
        do_push  = 1'b0;
        do_pop   = 1'b0;
        do_comb  = 1'b0;
        do_store = 1'b0;
        ovf_set  = 1'b0;
        udf_set  = 1'b0;
        stop     = 1'b0;
        if (running) begin
            case (opcode)
                OP_LOAD: begin
                    if (stk_full) ovf_set = 1'b1;
                    else          do_push = 1'b1;
                end
                OP_STORE: begin
                    if (stk_empty) udf_set = 1'b1;
                    else begin
                        do_pop   = 1'b1;
                        do_store = 1'b1;
                    end
                end
                OP_ADD, OP_MUL: begin
                    if (!stk_two) udf_set = 1'b1;
                    else          do_comb = 1'b1;
                end
                OP_DUP: begin
                    if (stk_empty)     udf_set = 1'b1;
                    else if (stk_full) ovf_set = 1'b1;
                    else               do_push = 1'b1;
                end
                default: stop = 1'b1;
            endcase
        end
    end

    // Program counter and error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else if (restart) begin
            pc_q  <= '0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else if (running) begin
            if (ovf_set) ovf_q <= 1'b1;
            if (udf_set) udf_q <= 1'b1;
            if (!(stop || ovf_set || udf_set)) pc_q <= pc_q + IMEM_AW'(1);
        end
    end

    assign stk_wdata = do_comb ? alu_res :
                       (opcode == OP_DUP) ? stk_top : mem_rd;

    sm_ram #(.DW(INSTR_W), .AW(IMEM_AW)) u_imem (
        .clk   (clk),
        .we    (imem_we && !running),
        .waddr (imem_addr),
        .wdata (imem_wdata),
        .raddr (pc_q),
        .rdata (instr)
    );

    sm_ram #(.DW(DATA_W), .AW(DMEM_AW)) u_dmem (
        .clk   (clk),
        .we    (running ? do_store : dmem_we),
        .waddr (running ? maddr : dmem_addr),
        .wdata (running ? stk_top : dmem_wdata),
        .raddr (running ? maddr : dmem_addr),
        .rdata (mem_rd)
    );

    sm_alu #(.DW(DATA_W)) u_alu (
        .do_mul (opcode == OP_MUL),
        .lhs    (stk_second),
        .rhs    (stk_top),
        .res    (alu_res)
    );

    sm_stack #(.DW(DATA_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .push    (do_push),
        .pop     (do_pop),
        .combine (do_comb),
        .wdata   (stk_wdata),
        .top     (stk_top),
        .second  (stk_second),
        .count   (stk_count)
    );

    assign dmem_rdata    = mem_rd;
    assign halted        = (state_q == S_DONE);
    assign err_overflow  = ovf_q;
    assign err_underflow = udf_q;
endmodule

// File: rtl/sm_core_chk.sv
module sm_core_chk
    import sm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       running,
    input logic [OP_W-1:0]            opcode,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic [DATA_W-1:0]          top,
    input logic                       halted,
    input logic                       ovf,
    input logic                       udf
);
    localparam int CW = $clog2(DEPTH + 1);

    p_depth_limit_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> halted);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> (halted && count == $past(count)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udf) |-> (halted && count == $past(count)));

    p_load_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && opcode == OP_LOAD && count < CW'(DEPTH))
        |=> count == $past(count) + CW'(1));

    p_combine_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (opcode == OP_ADD || opcode == OP_MUL) && count >= CW'(2))
        |=> count == $past(count) - CW'(1));

    p_dup_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && opcode == OP_DUP && count != '0 && count < CW'(DEPTH))
        |=> (top == $past(top) && count == $past(count) + CW'(1)));
endmodule

bind sm_core sm_core_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .running (running),
    .opcode  (opcode),
    .count   (stk_count),
    .top     (stk_top),
    .halted  (halted),
    .ovf     (err_overflow),
    .udf     (err_underflow)
);

// File: tb/tb_sm_core.sv
`timescale 1ns/1ps
module tb_sm_core;
    localparam int HLT = 0, LD = 1, ST = 2, AD = 3, MU = 4, DP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_addr = '0;
    logic [15:0] imem_wdata = '0;
    logic        dmem_we = 1'b0;
    logic [5:0]  dmem_addr = '0;
    logic [31:0] dmem_wdata = '0;
    logic [31:0] dmem_rdata;
    logic        halted, err_overflow, err_underflow;

    int n_cmp = 0;
    int n_bad = 0;
    int pc_w = 0;

    always #2.5 clk = ~clk;

    sm_core dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .imem_we(imem_we), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_rdata), .halted(halted),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int op, input int fld);
        @(negedge clk);
        imem_we = 1'b1; imem_addr = 6'(pc_w); imem_wdata = {4'(op), 12'(fld)};
        @(negedge clk);
        imem_we = 1'b0;
        pc_w++;
    endtask

    task automatic poke(input int a, input logic [31:0] v);
        @(negedge clk);
        dmem_we = 1'b1; dmem_addr = 6'(a); dmem_wdata = v;
        @(negedge clk);
        dmem_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [31:0] v);
        @(negedge clk);
        dmem_addr = 6'(a);
        #0.5 v = dmem_rdata;
    endtask

    // Pulse start, count clocks to halted; optionally try preload writes mid-run
    task automatic run(input string req, input int exp_cyc, input bit try_write);
        int cyc;
        pc_w = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        while (!halted && cyc < 300) begin
            if (try_write && cyc == 1) begin
                dmem_we = 1'b1; dmem_addr = 6'd50; dmem_wdata = 32'hBAD;
                imem_we = 1'b1; imem_addr = 6'd10; imem_wdata = {4'(LD), 12'd0};
            end else begin
                dmem_we = 1'b0; imem_we = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        dmem_we = 1'b0; imem_we = 1'b0;
        chk({req, " halt cycle"}, 32'(cyc), 32'(exp_cyc));
    endtask

    task automatic flags(input string req, input logic o, input logic u);
        chk({req, " overflow flag"}, {31'd0, err_overflow}, {31'd0, o});
        chk({req, " underflow flag"}, {31'd0, err_underflow}, {31'd0, u});
    endtask

    task automatic sc_reset;
        chk("R1 halted", {31'd0, halted}, 32'd0);
        flags("R1", 1'b0, 1'b0);
    endtask

    task automatic sc_expr;
        logic [31:0] v;
        poke(48, 7); poke(12, 5); poke(20, 3); poke(32, 4); poke(0, 1);
        put(LD, 20); put(LD, 32); put(AD, 0); put(LD, 48); put(LD, 12);
        put(AD, 0); put(MU, 0); put(ST, 40);
        for (int i = 0; i < 8; i++) put(LD, 0);
        put(HLT, 0);
        run("R2 R12 expression", 17, 1'b0);
        peek(40, v); chk("R8 R6 R7 (B+C)*(D+E)", v, 32'd84);
        flags("R12 balanced depth then full stack", 1'b0, 1'b0);
    endtask

    task automatic sc_arith;
        logic [31:0] v;
        poke(1, 32'h0001_0000); poke(3, 32'hFFFF_FFFF); poke(4, 2);
        poke(6, 9); poke(9, 6); poke(10, 7);
        put(LD, 12'hFC1); put(DP, 12'hABC); put(MU, 12'h555); put(ST, 2);
        put(LD, 3); put(LD, 4); put(AD, 12'hFFF); put(ST, 5);
        put(LD, 6); put(DP, 0); put(ST, 7); put(ST, 8);
        put(LD, 9); put(LD, 10); put(MU, 0); put(ST, 11);
        put(HLT, 0);
        run("R2 arithmetic", 17, 1'b0);
        peek(2, v);  chk("R8 R10 R6 product wraps", v, 32'd0);
        peek(5, v);  chk("R8 R10 sum wraps", v, 32'd1);
        peek(7, v);  chk("R9 duplicate top", v, 32'd9);
        peek(8, v);  chk("R9 original kept", v, 32'd9);
        peek(11, v); chk("R8 product", v, 32'd42);
        flags("R5", 1'b0, 1'b0);
    endtask

    task automatic sc_lifo;
        logic [31:0] v;
        for (int i = 0; i < 8; i++) poke(13 + i, 100 + i);
        for (int i = 0; i < 8; i++) put(LD, 13 + i);
        for (int i = 0; i < 8; i++) put(ST, 24 + i);
        put(HLT, 0);
        run("R12 lifo", 17, 1'b0);
        for (int j = 0; j < 8; j++) begin
            peek(24 + j, v); chk("R12 last-in first-out", v, 32'(107 - j));
        end
    endtask

    task automatic sc_overflow;
        logic [31:0] v;
        poke(33, 32'hDEAD);
        for (int i = 0; i < 9; i++) put(LD, 0);
        put(ST, 33); put(HLT, 0);
        run("R3 load overflow", 9, 1'b0);
        flags("R3 load", 1'b1, 1'b0);
        peek(33, v); chk("R3 nothing after fault", v, 32'hDEAD);
        for (int i = 0; i < 8; i++) put(LD, 0);
        put(DP, 0); put(HLT, 0);
        run("R3 dup overflow", 9, 1'b0);
        flags("R3 dup", 1'b1, 1'b0);
    endtask

    task automatic sc_underflow;
        logic [31:0] v;
        poke(34, 32'hBEEF);
        put(ST, 34); put(HLT, 0);
        run("R4 store empty", 1, 1'b0);
        flags("R4 store", 1'b0, 1'b1);
        peek(34, v); chk("R4 no write", v, 32'hBEEF);
        put(LD, 0); put(AD, 0); put(ST, 34); put(HLT, 0);
        run("R4 add one entry", 2, 1'b0);
        flags("R4 add", 1'b0, 1'b1);
        peek(34, v); chk("R4 no later store", v, 32'hBEEF);
        put(DP, 0); put(HLT, 0);
        run("R4 dup empty", 1, 1'b0);
        flags("R4 dup", 1'b0, 1'b1);
        put(HLT, 0);
        run("R2 restart clears flags", 1, 1'b0);
        flags("R2 restart", 1'b0, 1'b0);
    endtask

    task automatic sc_illegal;
        logic [31:0] v;
        poke(35, 32'h1234);
        put(LD, 6); put(4'hA, 0); put(ST, 35); put(HLT, 0);
        run("R5 unused opcode halts", 2, 1'b0);
        flags("R5 unused opcode", 1'b0, 1'b0);
        peek(35, v); chk("R5 no store after", v, 32'h1234);
    endtask

    task automatic sc_preload_locked;
        logic [31:0] v;
        poke(50, 32'h50); poke(52, 32'h77);
        for (int i = 0; i < 5; i++) begin put(LD, 52); put(ST, 53); end
        put(HLT, 0);
        run("R11 imem write ignored", 11, 1'b1);
        peek(50, v); chk("R11 dmem write ignored", v, 32'h50);
        peek(53, v); chk("R11 program result", v, 32'h77);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        sc_reset;
        rst_n = 1'b1;
        @(negedge clk);
        sc_reset;
        sc_expr;
        sc_arith;
        sc_lifo;
        sc_overflow;
        sc_underflow;
        sc_illegal;
        sc_preload_locked;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule